// File: doc/BRIEF.md
# Drive-Supply Charge Regulation Controller

This block holds the on/off decision for the current source that charges the drive-supply capacitor of a transducer burst driver. It takes a comparator flag that says the capacitor is above its target voltage and brings it into the clock domain through a synchronizer. From that flag, the burst-active and burst-done indications, and a small set of control bits, it computes a single charge-enable output. It also passes the target-level and charge-current selection codes straight to the analog section. It raises a ready bit once the supply has stayed above target for long enough that a new burst may start.

Regulation stays off from power-up until software clears a high-impedance control bit, because the capacitor may be fed from an outside supply. Once regulation is on, charging runs whenever the synchronized flag is low, so the capacitor is topped up intermittently. An optional listen-mode suppression switches charging off after a burst to keep switching noise out of the receive path. A rising edge of a software trigger bit turns charging back on. If that trigger bit is still set when the next burst begins, suppression is skipped after that burst. All control and status pins are plain levels or pulses. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `chg_supply_ctrl`

## Requirements
- R1: After reset, the high-impedance bit is 1, chg_en is 0, vrdy is 0, and lvl_code and cur_code are 0. chg_en stays 0 even while the comparator reads below target.
- R2: When cfg_we is high at a rising clock edge, all control fields are loaded at that edge. From then on, lvl_code (4 bits) and cur_code (2 bits) show the written values. When cfg_we is low, they hold their values.
- R3: With regulation enabled and no suppression, chg_en is 1 while the comparator is below target. After cmp_above_a rises, chg_en falls after the second rising clock edge, because of the two-flop synchronizer.
- R4: When the comparator drops below target again and there is no suppression, chg_en returns to 1 after the second rising clock edge (top-up).
- R5: vrdy rises after the synchronized flag has been high for 4 consecutive edges, which is the sixth edge after cmp_above_a rises. vrdy falls one edge after the synchronized flag falls, which is the third edge after cmp_above_a falls.
- R6: Suppression is latched, and chg_en forced to 0, under all of these conditions: burst_done is pulsed, the listen-off bit is 1, the trigger bit was 0 at the last rising edge of burst_active, and the high-impedance bit is 0. The latch holds until it is released.
- R7: A 0-to-1 change of the stored trigger bit releases suppression at the edge after the write. chg_en is still 0 right after the write edge and becomes 1 one edge later.
- R8: If the trigger bit is 1 at the rising edge of burst_active, the burst_done that follows does not latch suppression, even with the listen-off bit set.
- R9: While the high-impedance bit is 1, chg_en is 0, suppression is cleared, and burst_done latches nothing. After the bit is cleared, charging resumes without a trigger.
- R10: With the listen-off bit at 0, burst_done never latches suppression.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_above_a | input | 1 | Asynchronous comparator flag, 1 = supply above target |
| burst_active | input | 1 | High while a burst is being driven |
| burst_done | input | 1 | Single-cycle pulse at the end of a burst |
| cfg_we | input | 1 | Loads all control fields |
| cfg_hiz | input | 1 | High-impedance control bit (1 = regulation off) |
| cfg_lstn_off | input | 1 | Listen-off bit: suppress charging after a burst |
| cfg_trig | input | 1 | Recharge trigger bit |
| cfg_level | input | 4 | Target-level selection code |
| cfg_cur | input | 2 | Charge-current selection code |
| chg_en | output | 1 | Charge current source enable |
| lvl_code | output | 4 | Target-level code to the analog section |
| cur_code | output | 2 | Current code to the analog section |
| vrdy | output | 1 | Supply at target, ready for a burst |

## Verification
The comparator flag is stepped up and down with regulation enabled, and each output is sampled on the exact edges where it should change and one edge before. This separates a correct two-stage synchronizer and a four-cycle qualifier from ones that are off by a cycle. Bursts are run under four control settings: listen-off set with the trigger clear, the trigger left set at burst start, listen-off clear, and the high-impedance bit set. These runs tell apart the conditions that latch suppression, skip it, or block it. The trigger release is sampled on both sides of its one-edge delay.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } chg_state_e;

  localparam logic HIZ_RESET = 1'b1;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[i] <= 1'b0;
          else        sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/chg_ready_qual.sv
module chg_ready_qual #(
  parameter int READY_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above,
  output logic ready
);
  localparam int CW = $clog2(READY_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(READY_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!above)       cnt <= '0;
    else if (cnt != CMAX)  cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == CMAX);

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !above |=> !ready); // R5
  AST_READY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(above)); // R5
endmodule

// File: rtl/chg_supp_ctrl.sv
module chg_supp_ctrl
  import chg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hiz,
  input  logic lstn_off,
  input  logic trig,
  input  logic burst_active,
  input  logic burst_done,
  output logic hold
);
  chg_state_e state, state_nx;
  logic trig_prev, bact_prev, skip_q;
  logic trig_edge, bact_rise;

  assign trig_edge = trig & ~trig_prev;
  assign bact_rise = burst_active & ~bact_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_prev <= 1'b0;
      bact_prev <= 1'b0;
      skip_q    <= 1'b0;
    end else begin
      trig_prev <= trig;
      bact_prev <= burst_active;
      if (bact_rise) skip_q <= trig;
    end
  end

  always_comb begin
    state_nx = state;
    if (hiz)                                   state_nx = ST_RUN;
    else if (trig_edge)                        state_nx = ST_RUN;
    else if (burst_done && lstn_off && !skip_q) state_nx = ST_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= state_nx;
  end

  assign hold = (state == ST_HOLD);

  AST_ENTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && lstn_off && !skip_q && !hiz && !trig_edge) |=> hold); // R6
  AST_TRIG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |=> !hold); // R7
  AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && skip_q && !hold) |=> !hold); // R8
  AST_HIZ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hiz |=> !hold); // R9
  AST_LSTN_OFF_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !lstn_off) |=> !hold); // R10
endmodule

// File: rtl/chg_supply_ctrl.sv
module chg_supply_ctrl
  import chg_pkg::*;
#(
  parameter int LVL_W       = 4,
  parameter int CUR_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int READY_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_above_a,
  input  logic             burst_active,
  input  logic             burst_done,
  input  logic             cfg_we,
  input  logic             cfg_hiz,
  input  logic             cfg_lstn_off,
  input  logic             cfg_trig,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic [CUR_W-1:0] cfg_cur,
  output logic             chg_en,
  output logic [LVL_W-1:0] lvl_code,
  output logic [CUR_W-1:0] cur_code,
  output logic             vrdy
);
  logic hiz_q, lstn_q, trig_q;
  logic above_s, hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_q    <= HIZ_RESET;
      lstn_q   <= 1'b0;
      trig_q   <= 1'b0;
      lvl_code <= '0;
      cur_code <= '0;
    end else if (cfg_we) begin
      hiz_q    <= cfg_hiz;
      lstn_q   <= cfg_lstn_off;
      trig_q   <= cfg_trig;
      lvl_code <= cfg_level;
      cur_code <= cfg_cur;
    end
  end

  chg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_above_a), .q(above_s)
  );

  chg_ready_qual #(.READY_CYC(READY_CYC)) i_rdy (
    .clk(clk), .rst_n(rst_n), .above(above_s), .ready(vrdy)
  );

  chg_supp_ctrl i_supp (
    .clk(clk), .rst_n(rst_n), .hiz(hiz_q), .lstn_off(lstn_q), .trig(trig_q),
    .burst_active(burst_active), .burst_done(burst_done), .hold(hold)
  );

  assign chg_en = !hiz_q && !hold && !above_s;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(lvl_code) && $stable(cur_code))); // R2
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (lvl_code == $past(cfg_level))); // R2
endmodule

// File: tb/test_chg_supply_ctrl.sv
module test_chg_supply_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_above_a = 1'b0, burst_active = 1'b0, burst_done = 1'b0;
  logic cfg_we = 1'b0, cfg_hiz = 1'b1, cfg_lstn_off = 1'b0, cfg_trig = 1'b0;
  logic [3:0] cfg_level = '0;
  logic [1:0] cfg_cur = '0;
  logic chg_en, vrdy;
  logic [3:0] lvl_code;
  logic [1:0] cur_code;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  chg_supply_ctrl i_chg_supply_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_above_a(cmp_above_a),
    .burst_active(burst_active), .burst_done(burst_done),
    .cfg_we(cfg_we), .cfg_hiz(cfg_hiz), .cfg_lstn_off(cfg_lstn_off),
    .cfg_trig(cfg_trig), .cfg_level(cfg_level), .cfg_cur(cfg_cur),
    .chg_en(chg_en), .lvl_code(lvl_code), .cur_code(cur_code), .vrdy(vrdy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic hz, input logic lo, input logic tg,
                    input logic [3:0] lv, input logic [1:0] cu);
    cfg_hiz = hz; cfg_lstn_off = lo; cfg_trig = tg;
    cfg_level = lv; cfg_cur = cu; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic burst();
    burst_active = 1'b1;
    wait_n(3);
    burst_active = 1'b0;
    burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 chg_en", chg_en, 0);
    chk("R1 vrdy", vrdy, 0);
    chk("R1 lvl_code", lvl_code, 0);
    chk("R1 cur_code", cur_code, 0);
    wait_n(3);
    chk("R1 hiz keeps chg_en low", chg_en, 0);
  endtask

  task automatic t_cfg();
    wr(1'b0, 1'b0, 1'b0, 4'd9, 2'd2);
    chk("R2 lvl_code", lvl_code, 9);
    chk("R2 cur_code", cur_code, 2);
    chk("R3 charge below target", chg_en, 1);
    wait_n(2);
    chk("R2 lvl_code held", lvl_code, 9);
  endtask

  task automatic t_threshold();
    cmp_above_a = 1'b1;
    wait_n(1);
    chk("R3 still charging after 1 edge", chg_en, 1);
    wait_n(1);
    chk("R3 off after 2 edges", chg_en, 0);
    wait_n(3);
    chk("R5 vrdy low after 5 edges", vrdy, 0);
    wait_n(1);
    chk("R5 vrdy high after 6 edges", vrdy, 1);
    cmp_above_a = 1'b0;
    wait_n(1);
    chk("R4 still off after 1 edge", chg_en, 0);
    wait_n(1);
    chk("R4 top-up after 2 edges", chg_en, 1);
    chk("R5 vrdy held 2 edges after drop", vrdy, 1);
    wait_n(1);
    chk("R5 vrdy low 3 edges after drop", vrdy, 0);
  endtask

  task automatic t_suppress();
    wr(1'b0, 1'b1, 1'b0, 4'd9, 2'd2);
    chk("R6 charging before burst", chg_en, 1);
    burst();
    chk("R6 suppressed after burst", chg_en, 0);
    wait_n(5);
    chk("R6 suppression latched", chg_en, 0);
    wr(1'b0, 1'b1, 1'b1, 4'd9, 2'd2);
    chk("R7 still off right after write", chg_en, 0);
    wait_n(1);
    chk("R7 trigger re-enables", chg_en, 1);
  endtask

  task automatic t_skip();
    burst();
    chk("R8 trigger set at burst start skips", chg_en, 1);
    wait_n(4);
    chk("R8 still charging", chg_en, 1);
    wr(1'b0, 1'b1, 1'b0, 4'd9, 2'd2);
    burst();
    chk("R6 cleared trigger re-arms suppression", chg_en, 0);
  endtask

  task automatic t_hiz();
    wr(1'b1, 1'b1, 1'b0, 4'd9, 2'd2);
    chk("R9 hiz forces off", chg_en, 0);
    burst();
    chk("R9 hiz off during burst", chg_en, 0);
    wr(1'b0, 1'b1, 1'b0, 4'd9, 2'd2);
    chk("R9 resumes after hiz cleared", chg_en, 1);
  endtask

  task automatic t_lstn_off();
    wr(1'b0, 1'b0, 1'b0, 4'd3, 2'd1);
    burst();
    chk("R10 no suppression", chg_en, 1);
    wait_n(3);
    chk("R10 still charging", chg_en, 1);
    chk("R2 new lvl_code", lvl_code, 3);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_cfg();
    t_threshold();
    t_suppress();
    t_skip();
    t_hiz();
    t_lstn_off();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule